// File: doc/BRIEF.md
# Debounced Auto-Repeat Up/Down Counter

This block turns two push buttons into an 8-bit position value for a trimming potentiometer or a DAC code. Both buttons are active low and rest high. A low level from a switch closing to ground or from a logic driver counts as a press once it has lasted the debounce interval. Shorter lows do nothing. One button raises the value and the other lowers it.

A press gives one step. If the button stays down, steps repeat at a slow rate for the first second of the hold. After that they repeat at a fast rate until the button is released. Release returns the block to idle, and the next press starts again with a single step. The value clamps at both ends and never wraps.

All intervals are given in milliseconds and timed by a millisecond tick. The tick is derived from the clock frequency parameter, so a bench can scale the intervals down. A load port writes a recalled value at power-up. A freeze input holds both the value and the scan timing. The buttons only change the live value. Keeping the value across power cycles is up to the surrounding logic.

Top module: `btn_tap_counter`

## Requirements
- R1: After reset the value `tap` is 0x00 and the scan logic is idle.
- R2: Buttons are active low. A low on `btn_up_n` or `btn_dn_n` that lasts less than the debounce interval (default 30 ms) produces no step.
- R3: A low on `btn_up_n` held for the debounce interval raises `tap` by one. A low on `btn_dn_n` held for the same interval lowers it by one.
- R4: While the button stays held after the first step, a further step occurs every 250 ms during the first 1000 ms after that first step (slow mode).
- R5: From 1000 ms after the first step, steps occur every 50 ms until release (fast mode).
- R6: On release no further step occurs, and a new press again needs a full debounce interval before its single first step.
- R7: `tap` saturates. It stays at 0xFF when stepped up and at 0x00 when stepped down.
- R8: While both buttons are pressed no step occurs and the scan logic returns to idle. A button that stays held after the other is released starts a new debounce.
- R9: `load_en` high at a clock edge sets `tap` to `load_val` at that edge. This takes priority over stepping and over `freeze`.
- R10: While `freeze` is high, `tap` and all scan timing hold. Timing continues from where it stopped once `freeze` falls.
- R11: The millisecond tick is `CLK_HZ/1000` clock cycles, and all intervals scale with `CLK_HZ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up_n | input | 1 | Raise button, active low, asynchronous |
| btn_dn_n | input | 1 | Lower button, active low, asynchronous |
| freeze | input | 1 | Holds value and scan timing while high |
| load_en | input | 1 | Writes `load_val` into the value |
| load_val | input | 8 | Value to load |
| tap | output | 8 | Live position value |

## Verification
The checker covers the rules that hold on every cycle. These are: the value moves by at most one per cycle unless loaded; it never wraps past either end; it is stable under freeze or while both buttons are down; and a load lands on the next edge. The scenarios have to show the timing: the rejection of short lows, the 30 ms first step, the 250 ms and 50 ms repeat rates, and the switch to fast mode after one second. They also show that timing frozen mid-debounce resumes instead of restarting.

// File: rtl/btn_tap_counter.sv
module btn_tap_counter #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int WIDTH       = 8,
  parameter int DEBOUNCE_MS = 30,
  parameter int SLOW_MS     = 250,
  parameter int FAST_MS     = 50,
  parameter int SLOW_SPAN_MS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_up_n,
  input  logic             btn_dn_n,
  input  logic             freeze,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] tap
);
  // R11: tick period derived from clock frequency
  localparam int TPM    = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int PRE_W  = (TPM > 1) ? $clog2(TPM) : 1;
  localparam int MS_MAX = (DEBOUNCE_MS > SLOW_MS) ?
                          ((DEBOUNCE_MS > FAST_MS) ? DEBOUNCE_MS : FAST_MS) :
                          ((SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS);
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam int HOLD_W = $clog2(SLOW_SPAN_MS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TPM - 1);
  localparam logic [MS_W-1:0]   DB_LAST   = MS_W'(DEBOUNCE_MS - 1);
  localparam logic [MS_W-1:0]   SLOW_LAST = MS_W'(SLOW_MS - 1);
  localparam logic [MS_W-1:0]   FAST_LAST = MS_W'(FAST_MS - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(SLOW_SPAN_MS - 1);
  localparam logic [WIDTH-1:0]  TOP       = {WIDTH{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_DB, S_SLOW, S_FAST} scan_t;

  logic [1:0]        up_sync, dn_sync;
  logic              up_p, dn_p, one_p, dir_q, dir_ok;
  logic [PRE_W-1:0]  pre_cnt;
  logic              tick;
  scan_t             state;
  logic [MS_W-1:0]   ms_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic              step;

  // R2: two-flop synchronisers, idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_sync <= 2'b11;
      dn_sync <= 2'b11;
    end else begin
      up_sync <= {up_sync[0], btn_up_n};
      dn_sync <= {dn_sync[0], btn_dn_n};
    end
  end

  assign up_p   = ~up_sync[1];
  assign dn_p   = ~dn_sync[1];
  assign one_p  = up_p ^ dn_p;
  assign dir_ok = one_p && (up_p == dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_cnt <= '0;
    else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
    else                    pre_cnt <= pre_cnt + 1'b1;
  end

  assign tick = (pre_cnt == PRE_LAST);

  // R3 R4 R5: a step fires when the running interval completes
  always_comb begin
    step = 1'b0;
    if (tick && !freeze && dir_ok) begin
      case (state)
        S_DB:    step = (ms_cnt == DB_LAST);
        S_SLOW:  step = (ms_cnt == SLOW_LAST);
        S_FAST:  step = (ms_cnt == FAST_LAST);
        default: step = 1'b0;
      endcase
    end
  end

  // R6 R8 R10: scan state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      dir_q    <= 1'b0;
      ms_cnt   <= '0;
      hold_cnt <= '0;
    end else if (!freeze) begin
      if (!one_p || (state != S_IDLE && up_p != dir_q)) begin
        state    <= S_IDLE;
        ms_cnt   <= '0;
        hold_cnt <= '0;
      end else begin
        case (state)
          S_IDLE: begin
            state  <= S_DB;
            dir_q  <= up_p;
            ms_cnt <= '0;
          end
          S_DB: if (tick) begin
            if (ms_cnt == DB_LAST) begin
              state    <= S_SLOW;
              ms_cnt   <= '0;
              hold_cnt <= '0;
            end else begin
              ms_cnt <= ms_cnt + 1'b1;
            end
          end
          S_SLOW: if (tick) begin
            hold_cnt <= hold_cnt + 1'b1;
            if (hold_cnt == HOLD_LAST) begin
              state  <= S_FAST;
              ms_cnt <= '0;
            end else if (ms_cnt == SLOW_LAST) begin
              ms_cnt <= '0;
            end else begin
              ms_cnt <= ms_cnt + 1'b1;
            end
          end
          S_FAST: if (tick) begin
            if (ms_cnt == FAST_LAST) ms_cnt <= '0;
            else                     ms_cnt <= ms_cnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R1 R7 R9: value register, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap <= '0;
    end else if (load_en) begin
      tap <= load_val;
    end else if (step) begin
      if (dir_q && tap != TOP)        tap <= tap + 1'b1;
      else if (!dir_q && tap != '0)   tap <= tap - 1'b1;
    end
  end

endmodule

// File: rtl/btn_tap_counter_chk.sv
module btn_tap_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             freeze,
  input logic             load_en,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] tap,
  input logic             up_p,
  input logic             dn_p
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  AST_RESET_ZERO: assert property (@(posedge clk) $rose(rst_n) |-> tap == '0); // R1

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ({1'b0, tap} == {1'b0, $past(tap)} ||
                  {1'b0, tap} == {1'b0, $past(tap)} + 1'b1 ||
                  {1'b0, tap} + 1'b1 == {1'b0, $past(tap)})); // R3

  AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == TOP && !load_en) |=> tap != '0); // R7

  AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == '0 && !load_en) |=> tap != TOP); // R7

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_p && dn_p && !load_en) |=> $stable(tap)); // R8

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> tap == $past(load_val)); // R9

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !load_en) |=> $stable(tap)); // R10

endmodule

bind btn_tap_counter btn_tap_counter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .load_en(load_en),
  .load_val(load_val), .tap(tap), .up_p(up_p), .dn_p(dn_p)
);

// File: tb/btn_tap_counter_tb_top.sv
module btn_tap_counter_tb_top;
  // R11: 4 clocks per ms, so all ms intervals shrink with CLK_HZ
  localparam int CLK_HZ = 4000;
  localparam int CPM    = CLK_HZ / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_up_n = 1'b1, btn_dn_n = 1'b1;
  logic       freeze = 1'b0, load_en = 1'b0;
  logic [7:0] load_val = 8'h00;
  logic [7:0] tap;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  btn_tap_counter #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_up_n(btn_up_n), .btn_dn_n(btn_dn_n),
    .freeze(freeze), .load_en(load_en), .load_val(load_val), .tap(tap)
  );

  task automatic check(input int exp, input string tag);
    total++;
    if (tap !== 8'(exp)) begin
      bad++;
      $display("FAIL %s: tap=%0h expected=%0h", tag, tap, exp);
    end
  endtask

  task automatic wait_ms(input int n);
    repeat (n * CPM) @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [7:0] v, input string tag);
    load_val = v;
    load_en  = 1'b1;
    @(posedge clk);
    #1;
    load_en = 1'b0;
    check(v, tag);
  endtask

  function automatic int steps_at(input int t);
    int s;
    if (t < 30) return 0;
    s = t - 30;
    if (s < 1000) return 1 + s / 250;
    return 5 + (s - 1000) / 50;
  endfunction

  // hold one button, sample midway between expected steps, then release
  task automatic scan(input bit up, input int base, input int nsamp);
    int elapsed, e, n;
    string tag;
    if (up) btn_up_n = 1'b0; else btn_dn_n = 1'b0;
    wait_ms(15);
    check(base, "R2 before debounce");
    elapsed = 15;
    e = base;
    for (int j = 0; j < nsamp; j++) begin
      int t = 55 + 50 * j;
      wait_ms(t - elapsed);
      elapsed = t;
      n = steps_at(t);
      e = up ? base + n : base - n;
      if (e > 255 || e < 0) tag = "R7 saturation";
      else if (j == 0)      tag = "R3 first step";
      else if (t - 30 < 1000) tag = "R4 slow repeat";
      else                  tag = "R5 fast repeat";
      if (e > 255) e = 255;
      if (e < 0)   e = 0;
      check(e, tag);
    end
    btn_up_n = 1'b1;
    btn_dn_n = 1'b1;
    wait_ms(120);
    check(e, "R6 no step after release");
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    check(0, "R1 reset value");
    rst_n = 1'b1;
    wait_ms(50);
    check(0, "R1 idle after reset");
  endtask

  task automatic t_glitch;
    do_load(8'h50, "R9 load");
    btn_up_n = 1'b0;
    wait_ms(20);
    btn_up_n = 1'b1;
    wait_ms(40);
    check(8'h50, "R2 short up low");
    btn_dn_n = 1'b0;
    wait_ms(25);
    btn_dn_n = 1'b1;
    wait_ms(40);
    check(8'h50, "R2 short down low");
  endtask

  task automatic t_single;
    btn_dn_n = 1'b0;
    wait_ms(60);
    btn_dn_n = 1'b1;
    wait_ms(20);
    check(8'h4F, "R3 single down");
    btn_up_n = 1'b0;
    wait_ms(20);
    check(8'h4F, "R6 new press needs debounce");
    wait_ms(20);
    btn_up_n = 1'b1;
    wait_ms(20);
    check(8'h50, "R6 new press single step");
  endtask

  task automatic t_both;
    do_load(8'h40, "R9 load");
    btn_up_n = 1'b0;
    btn_dn_n = 1'b0;
    wait_ms(100);
    check(8'h40, "R8 both pressed");
    btn_up_n = 1'b1;
    btn_dn_n = 1'b1;
    wait_ms(20);
    btn_up_n = 1'b0;
    wait_ms(50);
    check(8'h41, "R3 up step");
    btn_dn_n = 1'b0;
    wait_ms(300);
    check(8'h41, "R8 second button stops scan");
    btn_dn_n = 1'b1;
    wait_ms(15);
    check(8'h41, "R8 restart debounce");
    wait_ms(30);
    check(8'h42, "R8 restarted first step");
    btn_up_n = 1'b1;
    wait_ms(20);
  endtask

  task automatic t_freeze;
    do_load(8'h20, "R9 load");
    btn_up_n = 1'b0;
    wait_ms(10);
    freeze = 1'b1;
    wait_ms(200);
    check(8'h20, "R10 frozen value");
    do_load(8'h21, "R9 load under freeze");
    do_load(8'h20, "R9 load under freeze");
    freeze = 1'b0;
    wait_ms(10);
    check(8'h20, "R10 timing resumed not restarted");
    wait_ms(15);
    check(8'h21, "R10 step after resumed debounce");
    btn_up_n = 1'b1;
    wait_ms(20);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_single();
    do_load(8'h10, "R9 load");
    scan(1'b1, 8'h10, 34);
    do_load(8'hFD, "R9 load");
    scan(1'b1, 8'hFD, 30);
    do_load(8'h03, "R9 load");
    scan(1'b0, 8'h03, 12);
    t_both();
    t_freeze();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule